// File: doc/BRIEF.md
# Power-Regulating PID Controller with Ramp Override

This block sets the duty-cycle word of a switching pre-regulator that feeds a linear pass stage. It does not regulate an output voltage. It regulates the heat in the pass element. On every sample strobe it takes the measured voltage across the pass element and the load current, and multiplies them into a power figure. It then runs a PID law of that figure against a power target. The new duty word is registered on the same clock edge as the strobe. Between strobes nothing moves.

A feed-forward override protects the output from collapsing. It engages when the pass-element voltage falls below a threshold, or when software signals that the output settings have changed. While it is engaged, the duty climbs toward the maximum duty word by a programmable step on each sample, so inrush stays bounded. The override ends at the first sample with no trigger after the duty has reached the maximum. At that point the PID takes over from the ramp value without a bump, because the integrator is preloaded with it.

The controller has two named states. In MODE_PID the loop regulates. In MODE_RAMP the override drives the duty. Transition ENTER_RAMP (MODE_PID to MODE_RAMP) is taken on a sample that carries a trigger. Transition LEAVE_RAMP (MODE_RAMP to MODE_PID) is taken on a sample with no trigger while the duty is at or above the maximum duty word. Without a sample the state holds.

Top module: `pwr_pid_ctrl`

## Requirements
- R1: After reset the duty word is 0, the override flag is 0, and the integrator and both previous-sample registers are 0.
- R2: On a cycle without `smp_vld`, the duty word and the override flag keep their values. A `settings_chg` pulse only records a pending change and has no effect on the outputs until the next sample.
- R3: The power figure is `v_pass * i_load` and the error is `p_target - power`. On a regulating sample the duty is floor((KP*err + INTEG - KD*(power - prev_power)) / 2^FRAC). The gains are unsigned with FRAC fraction bits, and INTEG is the updated integrator.
- R4: On a regulating sample the integrator becomes sat(INTEG + KI*(err + prev_err)). Saturation is to the signed AW-bit range. The integrator keeps its old value when the output is clamped and throughout the override.
- R5: If the PID result is above `duty_max`, the duty is `duty_max`. Otherwise, if the result is below `duty_min`, the duty is `duty_min`. The upper bound is tested first.
- R6: A sample with `v_pass < collapse_thr` leads to MODE_RAMP. On every ramping sample the duty becomes min(duty + `ramp_step`, `duty_max`).
- R7: A `settings_chg` pulse in any cycle since the previous sample, or in the sample cycle itself, triggers the override on that sample exactly like a collapse.
- R8: In MODE_RAMP, a sample with no trigger while duty >= `duty_max` returns to MODE_PID. On that sample the duty stays unchanged and the integrator is loaded with duty * 2^FRAC.
- R9: The previous error and the previous power are updated on every sample in both states. The first regulating sample after the override therefore uses the values of the last ramping sample.
- R10: With zero load current and a positive target, the loop drives the duty up to `duty_max`.
- R11: `override_act` is 1 exactly while the controller is in MODE_RAMP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_vld | input | 1 | Sample strobe; the loop advances only when it is high |
| v_pass | input | VW | Voltage across the pass element, unsigned |
| i_load | input | IW | Load current, unsigned |
| p_target | input | VW+IW | Power target |
| kp | input | GW | Proportional gain, unsigned, FRAC fraction bits |
| ki | input | GW | Integral gain, unsigned, FRAC fraction bits |
| kd | input | GW | Derivative gain, unsigned, FRAC fraction bits |
| ramp_step | input | DW | Duty increment per ramping sample |
| collapse_thr | input | VW | Collapse threshold for the pass-element voltage |
| duty_min | input | DW | Lower duty bound |
| duty_max | input | DW | Upper duty bound and ramp target |
| settings_chg | input | 1 | Strobe: output settings were changed |
| duty | output | DW | Duty-cycle word for the modulator |
| override_act | output | 1 | High while the ramp override drives the duty |

## Verification
The bench builds the block with VW=IW=10, GW=12, FRAC=6, DW=10 and AW=40. With these values the power products and gain products stay small enough for a 64-bit behavioural model to hold them exactly. A ramp from mid-scale reaches a 900 maximum within about twenty samples, so the LEAVE_RAMP transition and the integrator preload show up in short runs. The DW value also lets moderate targets drive the PID sum past both clamp bounds. A long sweep of random measurements, settings strobes and collapse events then exercises the clamping, the anti-windup and the bumpless return together.

// File: rtl/pwr_pid_pkg.sv
package pwr_pid_pkg;
    typedef enum logic [0:0] {
        MODE_PID  = 1'b0,
        MODE_RAMP = 1'b1
    } mode_e;
endpackage

// File: rtl/pwr_pid_pv.sv
module pwr_pid_pv #(
    parameter int VW = 12,
    parameter int IW = 12
) (
    input  logic [VW-1:0]    v_pass,
    input  logic [IW-1:0]    i_load,
    input  logic [VW-1:0]    thr,
    output logic [VW+IW-1:0] pv,
    output logic             collapse
);
    localparam int PW = VW + IW;

    always_comb begin
        pv       = PW'(v_pass) * PW'(i_load);
        collapse = (v_pass < thr);
    end
endmodule

// File: rtl/pwr_pid_law.sv
module pwr_pid_law #(
    parameter int PW   = 24,
    parameter int GW   = 16,
    parameter int FRAC = 8,
    parameter int DW   = 12,
    parameter int AW   = 48
) (
    input  logic [PW-1:0]        pv,
    input  logic [PW-1:0]        pv_prev,
    input  logic [PW-1:0]        target,
    input  logic signed [PW:0]   e_prev,
    input  logic [GW-1:0]        kp,
    input  logic [GW-1:0]        ki,
    input  logic [GW-1:0]        kd,
    input  logic signed [AW-1:0] integ,
    input  logic [DW-1:0]        dmin,
    input  logic [DW-1:0]        dmax,
    output logic signed [PW:0]   err,
    output logic signed [AW-1:0] integ_nx,
    output logic [DW-1:0]        duty_nx,
    output logic                 clamped
);
    localparam int EW = PW + 1;
    localparam int MW = EW + GW + 2;
    localparam int SW = AW + 2;
    localparam logic signed [SW-1:0] IMAX = SW'({1'b0, {(AW-1){1'b1}}});
    localparam logic signed [SW-1:0] IMIN = -IMAX - SW'(1);

    logic signed [MW-1:0] kp_x, ki_x, kd_x, e_x, es_x, dpv_x;
    logic signed [MW-1:0] pterm, iinc, dterm;
    logic signed [SW-1:0] i_raw, i_sat, acc, shifted, hi_s, lo_s;

    always_comb begin
        err   = $signed({1'b0, target}) - $signed({1'b0, pv});
        kp_x  = MW'({1'b0, kp});
        ki_x  = MW'({1'b0, ki});
        kd_x  = MW'({1'b0, kd});
        e_x   = MW'(err);
        es_x  = MW'(err) + MW'(e_prev);
        dpv_x = MW'($signed({1'b0, pv})) - MW'($signed({1'b0, pv_prev}));
        pterm = kp_x * e_x;
        iinc  = ki_x * es_x;
        dterm = kd_x * dpv_x;

        i_raw = SW'(integ) + SW'(iinc);
        if (i_raw > IMAX)      i_sat = IMAX;
        else if (i_raw < IMIN) i_sat = IMIN;
        else                   i_sat = i_raw;

        acc     = SW'(pterm) + i_sat - SW'(dterm);
        shifted = acc >>> FRAC;
        hi_s    = SW'({1'b0, dmax});
        lo_s    = SW'({1'b0, dmin});

        if (shifted > hi_s) begin
            duty_nx = dmax;
            clamped = 1'b1;
        end else if (shifted < lo_s) begin
            duty_nx = dmin;
            clamped = 1'b1;
        end else begin
            duty_nx = shifted[DW-1:0];
            clamped = 1'b0;
        end
        integ_nx = clamped ? integ : i_sat[AW-1:0];
    end
endmodule

// File: rtl/pwr_pid_ramp.sv
module pwr_pid_ramp #(
    parameter int DW = 12
) (
    input  logic [DW-1:0] duty,
    input  logic [DW-1:0] step,
    input  logic [DW-1:0] dmax,
    output logic [DW-1:0] ramp_nx,
    output logic          at_max
);
    logic [DW:0] sum;

    always_comb begin
        sum     = {1'b0, duty} + {1'b0, step};
        ramp_nx = (sum > {1'b0, dmax}) ? dmax : sum[DW-1:0];
        at_max  = (duty >= dmax);
    end
endmodule

// File: rtl/pwr_pid_ctrl.sv
module pwr_pid_ctrl
    import pwr_pid_pkg::*;
#(
    parameter int VW   = 12,
    parameter int IW   = 12,
    parameter int GW   = 16,
    parameter int FRAC = 8,
    parameter int DW   = 12,
    parameter int AW   = 48
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               smp_vld,
    input  logic [VW-1:0]      v_pass,
    input  logic [IW-1:0]      i_load,
    input  logic [VW+IW-1:0]   p_target,
    input  logic [GW-1:0]      kp,
    input  logic [GW-1:0]      ki,
    input  logic [GW-1:0]      kd,
    input  logic [DW-1:0]      ramp_step,
    input  logic [VW-1:0]      collapse_thr,
    input  logic [DW-1:0]      duty_min,
    input  logic [DW-1:0]      duty_max,
    input  logic               settings_chg,
    output logic [DW-1:0]      duty,
    output logic               override_act
);
    localparam int PW = VW + IW;
    localparam int EW = PW + 1;

    mode_e                mode_q, mode_d;
    logic [PW-1:0]        pv, pv_prev_q;
    logic signed [EW-1:0] err, e_prev_q;
    logic signed [AW-1:0] integ_q, integ_nx, preload;
    logic [DW-1:0]        duty_q, duty_pid, ramp_nx;
    logic                 collapse, clamped, at_max, chg_pend_q, trigger;

    pwr_pid_pv #(.VW(VW), .IW(IW)) u_pv (
        .v_pass   (v_pass),
        .i_load   (i_load),
        .thr      (collapse_thr),
        .pv       (pv),
        .collapse (collapse)
    );

    pwr_pid_law #(.PW(PW), .GW(GW), .FRAC(FRAC), .DW(DW), .AW(AW)) u_law (
        .pv       (pv),
        .pv_prev  (pv_prev_q),
        .target   (p_target),
        .e_prev   (e_prev_q),
        .kp       (kp),
        .ki       (ki),
        .kd       (kd),
        .integ    (integ_q),
        .dmin     (duty_min),
        .dmax     (duty_max),
        .err      (err),
        .integ_nx (integ_nx),
        .duty_nx  (duty_pid),
        .clamped  (clamped)
    );

    pwr_pid_ramp #(.DW(DW)) u_ramp (
        .duty    (duty_q),
        .step    (ramp_step),
        .dmax    (duty_max),
        .ramp_nx (ramp_nx),
        .at_max  (at_max)
    );

    // Override request: collapse now, or a settings change since the last sample.
    assign trigger = collapse | chg_pend_q | settings_chg;
    assign preload = AW'(duty_q) << FRAC;

    // Next-state logic: ENTER_RAMP and LEAVE_RAMP
    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            MODE_PID: begin
                if (smp_vld && trigger) mode_d = MODE_RAMP;
            end
            MODE_RAMP: begin
                if (smp_vld && !trigger && at_max) mode_d = MODE_PID;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= MODE_PID;
        else        mode_q <= mode_d;
    end

    // Datapath and output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            duty_q     <= '0;
            integ_q    <= '0;
            e_prev_q   <= '0;
            pv_prev_q  <= '0;
            chg_pend_q <= 1'b0;
        end else if (smp_vld) begin
            pv_prev_q  <= pv;
            e_prev_q   <= err;
            chg_pend_q <= 1'b0;
            unique case (mode_q)
                MODE_PID: begin
                    if (trigger) begin
                        duty_q <= ramp_nx;
                    end else begin
                        duty_q  <= duty_pid;
                        integ_q <= integ_nx;
                    end
                end
                MODE_RAMP: begin
                    if (!trigger && at_max) integ_q <= preload;
                    else                    duty_q  <= ramp_nx;
                end
            endcase
        end else if (settings_chg) begin
            chg_pend_q <= 1'b1;
        end
    end

    assign duty         = duty_q;
    assign override_act = (mode_q == MODE_RAMP);
endmodule

// File: rtl/pwr_pid_chk.sv
module pwr_pid_chk #(
    parameter int VW = 12,
    parameter int DW = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          smp_vld,
    input logic [VW-1:0] v_pass,
    input logic [VW-1:0] collapse_thr,
    input logic [DW-1:0] ramp_step,
    input logic [DW-1:0] duty_min,
    input logic [DW-1:0] duty_max,
    input logic          settings_chg,
    input logic [DW-1:0] duty,
    input logic          override_act
);
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_vld |=> ($stable(duty) && $stable(override_act))); // R2

    AST_DUTY_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && !override_act && duty_min <= duty_max) |=>
        (override_act || (duty >= $past(duty_min) && duty <= $past(duty_max)))); // R5

    AST_COLLAPSE_ENTERS: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && v_pass < collapse_thr) |=> override_act); // R6

    AST_RAMP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && override_act && duty <= duty_max) |=>
        (!override_act || (duty >= $past(duty) && (duty - $past(duty)) <= $past(ramp_step)))); // R6

    AST_CHG_ENTERS: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && settings_chg) |=> override_act); // R7

    AST_EXIT_HOLDS_DUTY: assert property (@(posedge clk) disable iff (!rst_n)
        override_act |=> (override_act || $stable(duty))); // R8
endmodule

bind pwr_pid_ctrl pwr_pid_chk #(.VW(VW), .DW(DW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .smp_vld      (smp_vld),
    .v_pass       (v_pass),
    .collapse_thr (collapse_thr),
    .ramp_step    (ramp_step),
    .duty_min     (duty_min),
    .duty_max     (duty_max),
    .settings_chg (settings_chg),
    .duty         (duty),
    .override_act (override_act)
);

// File: tb/pwr_pid_ctrl_tb.sv
module pwr_pid_ctrl_tb;
    localparam int VW = 10, IW = 10, GW = 12, FRAC = 6, DW = 10, AW = 40;
    localparam int PW = VW + IW;
    localparam time CLK_PERIOD = 10ns;

    logic clk = 1'b0, rst_n = 1'b0, smp_vld = 1'b0, settings_chg = 1'b0;
    logic [VW-1:0] v_pass = '0, collapse_thr = '0;
    logic [IW-1:0] i_load = '0;
    logic [PW-1:0] p_target = '0;
    logic [GW-1:0] kp = '0, ki = '0, kd = '0;
    logic [DW-1:0] ramp_step = '0, duty_min = '0, duty_max = '0;
    logic [DW-1:0] duty;
    logic          override_act;

    int    n_cmp = 0, n_bad = 0;
    bit    done = 1'b0;
    string tag = "R1";

    longint m_duty, m_integ, m_eprev, m_pvprev;
    bit     m_ramp, m_pend;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwr_pid_ctrl #(.VW(VW), .IW(IW), .GW(GW), .FRAC(FRAC), .DW(DW), .AW(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .v_pass(v_pass), .i_load(i_load),
        .p_target(p_target), .kp(kp), .ki(ki), .kd(kd), .ramp_step(ramp_step),
        .collapse_thr(collapse_thr), .duty_min(duty_min), .duty_max(duty_max),
        .settings_chg(settings_chg), .duty(duty), .override_act(override_act)
    );

    // Behavioural reference model, advanced on the same edges as the design.
    always @(posedge clk) begin
        longint pv, e, rmp, inew, acc, s, imax, imin;
        bit trig;
        if (!rst_n) begin
            m_duty = 0; m_integ = 0; m_eprev = 0; m_pvprev = 0; m_ramp = 0; m_pend = 0;
        end else if (smp_vld) begin
            imax = (longint'(1) <<< (AW-1)) - 1;
            imin = -imax - 1;
            pv   = longint'(v_pass) * longint'(i_load);
            e    = longint'(p_target) - pv;
            trig = (v_pass < collapse_thr) || m_pend || settings_chg;
            rmp  = m_duty + longint'(ramp_step);
            if (rmp > longint'(duty_max)) rmp = longint'(duty_max);
            if (!m_ramp) begin
                if (trig) begin
                    m_duty = rmp; m_ramp = 1;
                end else begin
                    inew = m_integ + longint'(ki) * (e + m_eprev);
                    if (inew > imax) inew = imax;
                    if (inew < imin) inew = imin;
                    acc = longint'(kp) * e + inew - longint'(kd) * (pv - m_pvprev);
                    s   = acc >>> FRAC;
                    if (s > longint'(duty_max))      m_duty = longint'(duty_max);
                    else if (s < longint'(duty_min)) m_duty = longint'(duty_min);
                    else begin m_duty = s; m_integ = inew; end
                end
            end else begin
                if (!trig && m_duty >= longint'(duty_max)) begin
                    m_integ = m_duty * (longint'(1) <<< FRAC);
                    m_ramp  = 0;
                end else begin
                    m_duty = rmp;
                end
            end
            m_eprev = e; m_pvprev = pv; m_pend = 0;
        end else if (settings_chg) begin
            m_pend = 1;
        end
    end

    // Compare on every falling edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            n_cmp++;
            if (longint'(duty) != m_duty || override_act != m_ramp) begin
                n_bad++;
                $display("FAIL %s: duty=%0d expected=%0d override=%0d expected=%0d",
                         tag, duty, m_duty, override_act, m_ramp);
            end
        end
    end

    task automatic do_smp(input int v, input int i, input bit chg);
        v_pass = VW'(v); i_load = IW'(i); settings_chg = chg; smp_vld = 1'b1;
        @(negedge clk);
        smp_vld = 1'b0; settings_chg = 1'b0;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        kp = 12'd64; ki = 12'd16; kd = 12'd32; p_target = PW'(3000);
        duty_min = 10'd50; duty_max = 10'd900; collapse_thr = 10'd20; ramp_step = 10'd40;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        tag = "R1";
        n_cmp++;
        if (duty !== '0 || override_act !== 1'b0) begin
            n_bad++;
            $display("FAIL R1: duty=%0d expected=0 override=%0d expected=0", duty, override_act);
        end

        tag = "R2"; idle(8);

        tag = "R3/R4 law";
        for (int k = 0; k < 12; k++) begin
            do_smp(40 + k * 7, 30 + k * 3, 1'b0);
            idle(k % 3);
        end

        tag = "R5 clamp";
        p_target = PW'(900000);
        for (int k = 0; k < 4; k++) do_smp(100, 50, 1'b0);
        p_target = PW'(0);
        for (int k = 0; k < 4; k++) do_smp(500, 500, 1'b0);
        p_target = PW'(3000);

        tag = "R6 R11 collapse";
        for (int k = 0; k < 3; k++) do_smp(5, 100, 1'b0);
        tag = "R8 R9 exit";
        for (int k = 0; k < 30; k++) do_smp(300, 8, 1'b0);

        tag = "R7 R2 pending change";
        settings_chg = 1'b1; @(negedge clk); settings_chg = 1'b0;
        idle(3);
        for (int k = 0; k < 30; k++) do_smp(200, 12, 1'b0);
        tag = "R7 same-cycle change";
        do_smp(200, 12, 1'b1);
        for (int k = 0; k < 30; k++) do_smp(200, 14, 1'b0);

        tag = "R10 zero current";
        for (int k = 0; k < 10; k++) do_smp(400, 0, 1'b0);

        tag = "R3 R4 R5 R6 R7 sweep";
        for (int k = 0; k < 400; k++) begin
            if (k % 50 == 0) begin
                kp = GW'($urandom_range(0, 200));
                ki = GW'($urandom_range(0, 40));
                kd = GW'($urandom_range(0, 80));
                p_target = PW'($urandom_range(0, 20000));
            end
            if ($urandom_range(0, 19) == 0) begin
                settings_chg = 1'b1; @(negedge clk); settings_chg = 1'b0;
            end
            do_smp(($urandom_range(0, 15) == 0) ? int'($urandom_range(0, 19))
                                               : int'($urandom_range(20, 1023)),
                   int'($urandom_range(0, 300)), $urandom_range(0, 29) == 0);
            idle(int'($urandom_range(0, 2)));
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog: run did not complete, actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule